// File: doc/BRIEF.md
# Segment Table Walking Address Translator

The block turns a two-part virtual reference (a segment number and an offset within that segment) into a flat physical address. It reads the segment's descriptor from a table in memory, checks the reference against it, and then reads the target word. The table is located by a table-base input and bounded by a table-size input, both plain control pins. A segment number outside the table faults at once. Otherwise the block reads two descriptor words back to back. It then checks the offset against the segment length and the requested access type against the rights bits. Only a reference that passes every check makes the third read, of the target word.

The CPU side is a valid/ready request channel and a valid/ready response channel. Each accepted request produces exactly one response, carrying either a physical address with its data or a fault code. Back-pressure rules: a request is taken only on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so one reference is in flight at a time. Once `rsp_valid` rises, it and all response fields hold unchanged until a cycle with `rsp_ready` high. On the memory side, `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready` is seen high. The read data returns later on a single-cycle `mem_rsp_valid` strobe, which cannot be back-pressured.

Top module: `seg_walk_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 while `rsp_valid` and `mem_req_valid` are 0.
- R2: `req_ready` is high only when no reference is in flight. It drops after a request is accepted, and it rises again only after that request's response has been taken. Exactly one response is given per accepted request.
- R3: If the segment number is not less than `tbl_limit`, the response carries fault code 1 (missing segment) and no memory read is made. The table registers are sampled when the request is accepted.
- R4: Descriptor word 0 is read at `tbl_base + seg*8` and word 1 at `tbl_base + seg*8 + 4`. Word 0 bits [23:0] hold the segment base. Word 1 bits [23:0] hold the segment length, and word 1 bits 24, 25 and 26 grant read, write and execute. All other descriptor bits are ignored.
- R5: If the offset is not less than the segment length, the response carries fault code 2 (limit violation) and no target read is made. This check takes priority over R6.
- R6: Access code 0 is read, 1 is write and 2 is execute. If the matching rights bit is clear, or the code is 3, the response carries fault code 3 (rights violation) and no target read is made.
- R7: A reference that passes all checks gives fault code 0. Its physical address is (segment base + offset) modulo 2^24. The third memory read is at that address, zero-extended to 32 bits, and `rsp_data` is the word returned.
- R8: A faulted response has `rsp_paddr` and `rsp_data` equal to 0.
- R9: Under back-pressure, a pending response holds all its fields stable, and a pending memory request holds its address stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_base | input | 32 | Byte address of the descriptor table |
| tbl_limit | input | 5 | Number of valid table entries |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and accepting |
| req_seg | input | 4 | Segment number |
| req_off | input | 24 | Offset within the segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_fault | output | 2 | 0 none, 1 missing segment, 2 limit, 3 rights |
| rsp_paddr | output | 24 | Physical address, 0 on fault |
| rsp_data | output | 32 | Target word, 0 on fault |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Memory byte address |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Read data |

## Verification
The hardest cases to reach are the ones on exact boundaries. One is an offset equal to the segment length minus one, or equal to the length. Another is a segment number equal to the table size. A third is a base plus offset that crosses 2^24, all while memory stalls at random on both ready and latency. Directed references hit each of these boundaries with hand-built descriptors. Seeded random traffic uses short segment lengths, so offsets fall on both sides of the limit, with random rights bits and random garbage in the ignored descriptor bits. The bench logs every memory read address to confirm the read count and order for each fault outcome.

// File: rtl/seg_walk_pkg.sv
package seg_walk_pkg;
  localparam int PA_W   = 24;
  localparam int DATA_W = 32;
  localparam int RT_LSB = 24;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_NOSEG  = 2'd1,
    FLT_LIMIT  = 2'd2,
    FLT_RIGHTS = 2'd3
  } flt_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_BAD = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    PH_DLO = 2'd0,
    PH_DHI = 2'd1,
    PH_TGT = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } state_e;
endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4
) (
  input  logic [ADDR_W-1:0] tbase,
  input  logic [SEG_W-1:0]  seg,
  input  phase_e            phase,
  input  logic [PA_W-1:0]   paddr,
  output logic [ADDR_W-1:0] addr
);
  localparam int PAD_SEG = ADDR_W - SEG_W - 3;
  localparam int PAD_PA  = ADDR_W - PA_W;

  logic [ADDR_W-1:0] entry;

  always_comb begin
    entry = tbase + {{PAD_SEG{1'b0}}, seg, 3'b000};
    unique case (phase)
      PH_DLO:  addr = entry;
      PH_DHI:  addr = entry + ADDR_W'(4);
      default: addr = {{PAD_PA{1'b0}}, paddr};
    endcase
  end
endmodule

// File: rtl/seg_desc_check.sv
module seg_desc_check
  import seg_walk_pkg::*;
(
  input  logic [PA_W-1:0] off,
  input  logic [PA_W-1:0] seg_len,
  input  logic [2:0]      rights,
  input  acc_e            acc,
  output flt_e            fault
);
  logic granted;

  always_comb begin
    unique case (acc)
      ACC_RD:  granted = rights[0];
      ACC_WR:  granted = rights[1];
      ACC_EX:  granted = rights[2];
      default: granted = 1'b0;
    endcase
    if (off >= seg_len)  fault = FLT_LIMIT;
    else if (!granted)   fault = FLT_RIGHTS;
    else                 fault = FLT_NONE;
  end
endmodule

// File: rtl/seg_walk_ctrl.sv
module seg_walk_ctrl
  import seg_walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [SEG_W:0]    tbl_limit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [PA_W-1:0]   req_off,
  input  logic [1:0]        req_acc,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  flt_e              chk_fault,
  output logic [ADDR_W-1:0] cur_tbase,
  output logic [SEG_W-1:0]  cur_seg,
  output logic [PA_W-1:0]   cur_off,
  output acc_e              cur_acc,
  output phase_e            cur_phase,
  output logic [PA_W-1:0]   cur_paddr
);
  state_e          st;
  logic [PA_W-1:0] seg_base;
  flt_e            fault_q;
  logic [DATA_W-1:0] data_q;

  assign req_ready     = (st == ST_IDLE);
  assign rsp_valid     = (st == ST_RESP);
  assign mem_req_valid = (st == ST_ISSUE);
  assign rsp_fault     = fault_q;
  assign rsp_data      = data_q;
  assign rsp_paddr     = (fault_q == FLT_NONE) ? cur_paddr : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur_tbase <= '0;
      cur_seg   <= '0;
      cur_off   <= '0;
      cur_acc   <= ACC_RD;
      cur_phase <= PH_DLO;
      cur_paddr <= '0;
      seg_base  <= '0;
      fault_q   <= FLT_NONE;
      data_q    <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          cur_tbase <= tbl_base;
          cur_seg   <= req_seg;
          cur_off   <= req_off;
          cur_acc   <= acc_e'(req_acc);
          cur_phase <= PH_DLO;
          cur_paddr <= '0;
          data_q    <= '0;
          if ({1'b0, req_seg} >= tbl_limit) begin
            fault_q <= FLT_NOSEG;
            st      <= ST_RESP;
          end else begin
            fault_q <= FLT_NONE;
            st      <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (mem_req_ready) st <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          unique case (cur_phase)
            PH_DLO: begin
              seg_base  <= mem_rsp_data[PA_W-1:0];
              cur_phase <= PH_DHI;
              st        <= ST_ISSUE;
            end
            PH_DHI: begin
              if (chk_fault != FLT_NONE) begin
                fault_q <= chk_fault;
                st      <= ST_RESP;
              end else begin
                cur_paddr <= seg_base + cur_off;
                cur_phase <= PH_TGT;
                st        <= ST_ISSUE;
              end
            end
            default: begin
              data_q <= mem_rsp_data;
              st     <= ST_RESP;
            end
          endcase
        end
        default: if (rsp_ready) st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_walk_xlate.sv
module seg_walk_xlate
  import seg_walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [SEG_W:0]    tbl_limit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [PA_W-1:0]   req_off,
  input  logic [1:0]        req_acc,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  logic [ADDR_W-1:0] cur_tbase;
  logic [SEG_W-1:0]  cur_seg;
  logic [PA_W-1:0]   cur_off;
  logic [PA_W-1:0]   cur_paddr;
  acc_e              cur_acc;
  phase_e            cur_phase;
  flt_e              chk_fault;

  seg_walk_ctrl #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
    .req_off(req_off), .req_acc(req_acc), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .rsp_data(rsp_data), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .chk_fault(chk_fault),
    .cur_tbase(cur_tbase), .cur_seg(cur_seg), .cur_off(cur_off),
    .cur_acc(cur_acc), .cur_phase(cur_phase), .cur_paddr(cur_paddr)
  );

  seg_addr_gen #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_agen (
    .tbase(cur_tbase), .seg(cur_seg), .phase(cur_phase),
    .paddr(cur_paddr), .addr(mem_req_addr)
  );

  seg_desc_check u_chk_desc (
    .off(cur_off),
    .seg_len(mem_rsp_data[PA_W-1:0]),
    .rights(mem_rsp_data[RT_LSB+2:RT_LSB]),
    .acc(cur_acc),
    .fault(chk_fault)
  );
endmodule

// File: rtl/seg_walk_chk.sv
module seg_walk_chk #(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] tbl_base,
  input logic [SEG_W:0]    tbl_limit,
  input logic              req_valid,
  input logic              req_ready,
  input logic [SEG_W-1:0]  req_seg,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_fault,
  input logic [23:0]       rsp_paddr,
  input logic [31:0]       rsp_data,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr
);
  logic [1:0]        nrd;
  logic [ADDR_W-1:0] ent_addr;
  logic              accept;

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrd      <= '0;
      ent_addr <= '0;
    end else if (accept) begin
      nrd      <= '0;
      ent_addr <= tbl_base + {{(ADDR_W-SEG_W-3){1'b0}}, req_seg, 3'b000};
    end else if (mem_req_valid && mem_req_ready && nrd != 2'd3) begin
      nrd <= nrd + 2'd1;
    end
  end

  assert_idle_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !mem_req_valid));
  assert_one_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (!rsp_valid && req_ready));
  assert_noseg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && {1'b0, req_seg} >= tbl_limit) |=> (rsp_valid && rsp_fault == 2'd1));
  assert_noseg_noread_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd1) |-> (nrd == 2'd0));
  assert_desc_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && nrd == 2'd0) |-> (mem_req_addr == ent_addr));
  assert_desc_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && nrd == 2'd1) |-> (mem_req_addr == ent_addr + 32'd4));
  assert_chk_reads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault[1]) |-> (nrd == 2'd2));
  assert_ok_reads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd0) |-> (nrd == 2'd3));
  assert_fault_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0 && rsp_data == '0));
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault) &&
                                   $stable(rsp_paddr) && $stable(rsp_data)));
  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind seg_walk_xlate seg_walk_chk #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_walk_chk (
  .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
  .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
  .rsp_paddr(rsp_paddr), .rsp_data(rsp_data), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr)
);

// File: tb/sim_seg_walk_xlate.sv
`timescale 1ns/1ps
module sim_seg_walk_xlate;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] tbl_base = 32'h200;
  logic [4:0]  tbl_limit = 5'd12;
  logic        req_valid = 0;
  logic        req_ready;
  logic [3:0]  req_seg = 0;
  logic [23:0] req_off = 0;
  logic [1:0]  req_acc = 0;
  logic        rsp_valid;
  logic        rsp_ready = 0;
  logic [1:0]  rsp_fault;
  logic [23:0] rsp_paddr;
  logic [31:0] rsp_data;
  logic        mem_req_valid;
  logic        mem_req_ready = 0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;

  always #5 clk = ~clk;

  seg_walk_xlate u0 (.*);

  int checks = 0, errors = 0;
  logic [31:0] mem [0:255];
  logic [23:0] d_base [0:15];
  logic [23:0] d_len  [0:15];
  logic [2:0]  d_rt   [0:15];
  logic [31:0] rd_log [0:3];
  int          rd_n = 0;
  int          lat = 0;
  logic [31:0] pend_addr = 0;
  int          stall_pct = 50;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put_desc(input int s, input logic [23:0] b, input logic [23:0] l,
                          input logic [2:0] r);
    int w;
    d_base[s] = b; d_len[s] = l; d_rt[s] = r;
    w = int'(tbl_base[9:2]) + 2 * s;
    mem[w]     = {8'($urandom), b};
    mem[w + 1] = {5'($urandom), r, l};
  endtask

  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          mem_rsp_valid = 1;
          mem_rsp_data  = mem[pend_addr[9:2]];
        end
      end
      mem_req_ready = (lat == 0) && (($urandom % 100) >= stall_pct);
      if (mem_req_valid && mem_req_ready) begin
        pend_addr = mem_req_addr;
        lat = 1 + ($urandom % 3);
        if (rd_n < 4) rd_log[rd_n] = mem_req_addr;
        rd_n++;
      end
    end
  end

  task automatic run(input logic [3:0] s, input logic [23:0] off, input logic [1:0] acc);
    logic [1:0] e_f; logic [23:0] e_pa; logic [31:0] e_d; int e_n;
    logic [31:0] ent; string rq; bit held; logic [1:0] hf; logic [23:0] hp; logic [31:0] hd;
    bit granted;
    ent = tbl_base + {25'd0, s, 3'b000};
    granted = (acc == 2'd0) ? d_rt[s][0] : (acc == 2'd1) ? d_rt[s][1] :
              (acc == 2'd2) ? d_rt[s][2] : 1'b0;
    e_pa = 0; e_d = 0;
    if ({1'b0, s} >= tbl_limit) begin e_f = 1; e_n = 0; rq = "R3"; end
    else if (off >= d_len[s])   begin e_f = 2; e_n = 2; rq = "R5"; end
    else if (!granted)          begin e_f = 3; e_n = 2; rq = "R6"; end
    else begin
      e_f = 0; e_n = 3; rq = "R7";
      e_pa = d_base[s] + off;
      e_d  = mem[e_pa[9:2]];
    end
    @(negedge clk);
    rd_n = 0;
    req_seg = s; req_off = off; req_acc = acc; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R2", "ready low in flight", {31'd0, req_ready}, 32'd0);
    held = 0;
    forever begin
      if (held) begin
        chk(rsp_valid && rsp_fault == hf && rsp_paddr == hp && rsp_data == hd,
            "R9", "response held", {8'd0, rsp_paddr}, {8'd0, hp});
        held = 0;
      end
      if (rsp_valid) begin
        rsp_ready = ($urandom % 3) != 0;
        if (rsp_ready) break;
        held = 1; hf = rsp_fault; hp = rsp_paddr; hd = rsp_data;
      end
      @(negedge clk);
    end
    chk(rsp_fault == e_f, rq, "fault", {30'd0, rsp_fault}, {30'd0, e_f});
    chk(rsp_paddr == e_pa, (e_f == 0) ? "R7" : "R8", "paddr", {8'd0, rsp_paddr}, {8'd0, e_pa});
    chk(rsp_data == e_d, (e_f == 0) ? "R7" : "R8", "data", rsp_data, e_d);
    chk(rd_n == e_n, rq, "read count", rd_n, e_n);
    if (e_n >= 2 && rd_n >= 2) begin
      chk(rd_log[0] == ent, "R4", "desc word0 addr", rd_log[0], ent);
      chk(rd_log[1] == ent + 4, "R4", "desc word1 addr", rd_log[1], ent + 4);
    end
    if (e_n == 3 && rd_n >= 3)
      chk(rd_log[2] == {8'd0, e_pa}, "R7", "target addr", rd_log[2], {8'd0, e_pa});
    @(negedge clk);
    rsp_ready = 0;
    chk(req_ready && !rsp_valid, "R2", "idle after response", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic finish_up;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    for (int s = 0; s < 16; s++) put_desc(s, 24'($urandom), 24'($urandom % 64), 3'($urandom));
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1", "reset outputs",
        {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1", "idle after reset",
        {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'h4);

    put_desc(0, 24'hFFFFF0, 24'h40, 3'b111);
    put_desc(1, 24'h000100, 24'h0,  3'b111);
    put_desc(2, 24'h000080, 24'h10, 3'b001);
    put_desc(11, 24'h000020, 24'h8, 3'b100);
    run(0, 24'h20, 2'd0);
    run(0, 24'h3F, 2'd1);
    run(0, 24'h40, 2'd0);
    run(1, 24'h0,  2'd0);
    run(2, 24'hF,  2'd0);
    run(2, 24'h4,  2'd1);
    run(2, 24'h4,  2'd2);
    run(2, 24'h4,  2'd3);
    run(2, 24'h10, 2'd1);
    run(11, 24'h7, 2'd2);
    run(12, 24'h0, 2'd0);
    run(15, 24'h0, 2'd0);
    tbl_limit = 5'd0;
    run(0, 24'h20, 2'd0);
    tbl_limit = 5'd16;
    put_desc(15, 24'h000300, 24'h20, 3'b010);
    run(15, 24'h1F, 2'd1);
    tbl_base = 32'h100;
    for (int s = 0; s < 16; s++) put_desc(s, 24'($urandom), 24'(1 + $urandom % 48), 3'($urandom));
    tbl_limit = 5'd12;
    for (int i = 0; i < 400; i++) begin
      stall_pct = (i < 200) ? 50 : 10;
      run(4'($urandom), 24'($urandom % 56), 2'($urandom));
    end
    finish_up();
  end
endmodule